// File: doc/BRIEF.md
# Burst Address Sequencer for a Registered-Feedback Bus Master

This block sits on the master side of a 32-bit registered-feedback system bus. A request gives a start byte address, a length in beats, a transfer kind and a wrap size. The block then runs the bus cycle. It raises the cycle and strobe lines, presents one word address per beat, and drives the cycle-type and burst-type tags. It moves to the next beat on each cycle in which strobe and acknowledge are both high. The data words and the byte-lane selects are produced elsewhere and travel beside this block.

The controller has three named states. `ST_IDLE` keeps the bus quiet and accepts a request. `ST_BODY` drives every beat of a burst except the last. `ST_TAIL` drives the final beat, or the only beat of a single transfer. The transitions are:
- IDLE→TAIL on a single-beat request.
- IDLE→BODY on a multi-beat request.
- BODY→BODY on an acknowledge while two or more beats remain.
- BODY→TAIL on the acknowledge that leaves one beat.
- TAIL→IDLE on the final acknowledge.

Top module: `wb_burst_agen`

## Requirements
- R1: While reset is held and just after it is released, cyc_o and stb_o are 0, cti_o is 000, bte_o is 00 and adr_o is 0.
- R2: A request (start_i high) seen in idle makes cyc_o and stb_o high from the next cycle. The first beat's adr_o is start_adr_i with its two lowest bits forced to 0. Every adr_o has bits [1:0] at 0.
- R3: While stb_o is high and ack_i is low, cyc_o, stb_o, adr_o, cti_o and bte_o keep their values.
- R4: In an incrementing request (kind_i = 10) with linear wrap (wrap_i = 00), each acknowledged non-final beat adds 4 to adr_o. Non-final beats drive cti_o = 010 and bte_o = 00.
- R5: In an incrementing request with wrap_i = 01, 10 or 11, only the low 2, 3 or 4 bits of the word address (adr_o[31:2]) count up, modulo 4, 8 or 16. The higher bits stay fixed, and bte_o equals wrap_i on every beat.
- R6: In a constant-address request (kind_i = 01), adr_o never changes across beats. Non-final beats drive cti_o = 001, and every beat drives bte_o = 00.
- R7: The final beat of a burst of two or more beats drives cti_o = 111. In the cycle after that beat is acknowledged, cyc_o and stb_o are 0.
- R8: A request with len_i of 0 or 1, or with kind_i of 00 or 11 (classic), issues exactly one beat, with cti_o = 000 and bte_o = 00, whatever wrap_i is.
- R9: start_i is ignored while a transfer is in progress. The running burst's addresses and tags continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken only in idle |
| start_adr_i | input | 32 | Start byte address |
| len_i | input | 5 | Number of beats (0 is treated as 1) |
| kind_i | input | 2 | 00/11 classic, 01 constant address, 10 incrementing |
| wrap_i | input | 2 | 00 linear, 01 wrap 4, 10 wrap 8, 11 wrap 16 |
| ack_i | input | 1 | Slave acknowledge |
| cyc_o | output | 1 | Bus cycle active |
| stb_o | output | 1 | Strobe, valid beat |
| adr_o | output | 32 | Current byte address, word aligned |
| cti_o | output | 3 | Cycle-type tag |
| bte_o | output | 2 | Burst-type tag |

## Verification
A request drives its first beat exactly one clock after the edge that samples start_i. Each later beat appears one clock after the edge that carries its acknowledge. The bus goes quiet one clock after the final acknowledge. The bench drives inputs at the falling edge and checks each output at the next falling edge, so every sample falls half a period after the register that produced it. It models the address and tag sequence for each beat number and compares it against the pins. It inserts random stall cycles to confirm that outputs hold while no acknowledge arrives.

// File: rtl/wb_agen_pkg.sv
package wb_agen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BODY = 2'd1,
        ST_TAIL = 2'd2
    } agen_state_e;

    localparam logic [1:0] KIND_CLASSIC = 2'b00;
    localparam logic [1:0] KIND_CONST   = 2'b01;
    localparam logic [1:0] KIND_INCR    = 2'b10;

    localparam logic [2:0] CTI_CLASSIC  = 3'b000;
    localparam logic [2:0] CTI_CONST    = 3'b001;
    localparam logic [2:0] CTI_INCR     = 3'b010;
    localparam logic [2:0] CTI_END      = 3'b111;

    localparam logic [1:0] BTE_LINEAR   = 2'b00;

endpackage

// File: rtl/wb_agen_step.sv
module wb_agen_step #(
    parameter int WW = 30
) (
    input  logic [WW-1:0] cur_i,
    input  logic          hold_i,
    input  logic [1:0]    wrap_i,
    output logic [WW-1:0] nxt_o
);
    localparam int NWRAP = 3;

    logic [WW-1:0] mask_tab [NWRAP+1];
    logic [WW-1:0] mask;
    logic [WW-1:0] inc;

    assign mask_tab[0] = '1;
    for (genvar g = 1; g <= NWRAP; g++) begin : g_mask
        assign mask_tab[g] = WW'((64'd1 << (g + 1)) - 64'd1);
    end

    always_comb begin
        mask  = mask_tab[wrap_i];
        inc   = cur_i + WW'(1);
        if (hold_i) begin
            nxt_o = cur_i;
        end else begin
            nxt_o = (cur_i & ~mask) | (inc & mask);
        end
    end
endmodule

// File: rtl/wb_agen_beatcnt.sv
module wb_agen_beatcnt #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             one_left_o
);
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - LEN_W'(1);
        end
    end

    assign one_left_o = (cnt_q == LEN_W'(1));

    // R7: beats are only consumed while some remain
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (cnt_q != '0));
endmodule

// File: rtl/wb_burst_agen.sv
module wb_burst_agen
    import wb_agen_pkg::*;
#(
    parameter int ADR_W    = 32,
    parameter int WORD_LSB = 2,
    parameter int LEN_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [ADR_W-1:0] start_adr_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [1:0]       kind_i,
    input  logic [1:0]       wrap_i,
    input  logic             ack_i,
    output logic             cyc_o,
    output logic             stb_o,
    output logic [ADR_W-1:0] adr_o,
    output logic [2:0]       cti_o,
    output logic [1:0]       bte_o
);
    localparam int WW = ADR_W - WORD_LSB;

    agen_state_e   state_q, state_n;
    logic [WW-1:0] wadr_q, wadr_nxt;
    logic          hold_q;
    logic          single_q;
    logic [1:0]    wrap_q;
    logic          one_left;
    logic          accept;
    logic          req_single;
    logic          beat_done;
    logic          advance;

    assign accept     = (state_q == ST_IDLE) && start_i;
    assign req_single = (len_i < LEN_W'(2)) ||
                        (kind_i != KIND_CONST && kind_i != KIND_INCR);
    assign beat_done  = stb_o && ack_i;
    assign advance    = (state_q == ST_BODY) && beat_done;

    wb_agen_step #(.WW(WW)) u_step (
        .cur_i  (wadr_q),
        .hold_i (hold_q),
        .wrap_i (wrap_q),
        .nxt_o  (wadr_nxt)
    );

    wb_agen_beatcnt #(.LEN_W(LEN_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (req_single ? '0 : len_i - LEN_W'(1)),
        .dec_i      (advance),
        .one_left_o (one_left)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // transition logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)  state_n = req_single ? ST_TAIL : ST_BODY;
            ST_BODY: if (ack_i)    state_n = one_left ? ST_TAIL : ST_BODY;
            ST_TAIL: if (ack_i)    state_n = ST_IDLE;
            default:               state_n = ST_IDLE;
        endcase
    end

    // request context and running word address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wadr_q   <= '0;
            hold_q   <= 1'b0;
            single_q <= 1'b0;
            wrap_q   <= BTE_LINEAR;
        end else if (accept) begin
            wadr_q   <= start_adr_i[ADR_W-1:WORD_LSB];
            hold_q   <= (kind_i == KIND_CONST);
            single_q <= req_single;
            wrap_q   <= (req_single || kind_i == KIND_CONST) ? BTE_LINEAR : wrap_i;
        end else if (advance) begin
            wadr_q   <= wadr_nxt;
        end
    end

    // outputs
    always_comb begin
        cyc_o = 1'b0;
        stb_o = 1'b0;
        cti_o = CTI_CLASSIC;
        bte_o = BTE_LINEAR;
        adr_o = {wadr_q, {WORD_LSB{1'b0}}};
        unique case (state_q)
            ST_IDLE: begin
                adr_o = '0;
            end
            ST_BODY: begin
                cyc_o = 1'b1;
                stb_o = 1'b1;
                cti_o = hold_q ? CTI_CONST : CTI_INCR;
                bte_o = wrap_q;
            end
            ST_TAIL: begin
                cyc_o = 1'b1;
                stb_o = 1'b1;
                cti_o = single_q ? CTI_CLASSIC : CTI_END;
                bte_o = wrap_q;
            end
            default: ;
        endcase
    end

    // R3: a stalled beat keeps every output steady
    a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && !ack_i) |=> ($stable(adr_o) && $stable(cti_o) &&
                               $stable(bte_o) && cyc_o && stb_o));

    // R7: the bus is released right after the end-of-burst beat
    a_r7_drop_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && ack_i && cti_o == CTI_END) |=> (!cyc_o && !stb_o));

    // R6: a constant-address beat never moves the address
    a_r6_const_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && ack_i && cti_o == CTI_CONST) |=> $stable(adr_o));

    // R4: linear incrementing steps one word
    a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && ack_i && cti_o == CTI_INCR && bte_o == BTE_LINEAR) |=>
        (adr_o == $past(adr_o) + ADR_W'(1 << WORD_LSB)));

    // R5: wrapping never disturbs bits above the largest wrap window
    a_r5_wrap_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && ack_i && cti_o == CTI_INCR && bte_o != BTE_LINEAR) |=>
        $stable(adr_o[ADR_W-1:WORD_LSB+4]));

    // R8: classic beats carry the linear burst tag
    a_r8_classic_bte: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_o && cti_o == CTI_CLASSIC) |-> (bte_o == BTE_LINEAR));

    // R2: strobe only inside a cycle, address always word aligned
    a_r2_stb_in_cyc: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o == cyc_o) && (adr_o[WORD_LSB-1:0] == '0));
endmodule

// File: tb/wb_burst_agen_tb.sv
`timescale 1ns/1ps
module wb_burst_agen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [31:0] start_adr_i;
    logic [4:0]  len_i;
    logic [1:0]  kind_i;
    logic [1:0]  wrap_i;
    logic        ack_i;
    logic        cyc_o, stb_o;
    logic [31:0] adr_o;
    logic [2:0]  cti_o;
    logic [1:0]  bte_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    wb_burst_agen dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_adr_i(start_adr_i),
        .len_i(len_i), .kind_i(kind_i), .wrap_i(wrap_i), .ack_i(ack_i),
        .cyc_o(cyc_o), .stb_o(stb_o), .adr_o(adr_o), .cti_o(cti_o), .bte_o(bte_o)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [29:0] next_word(logic [29:0] w, logic [1:0] kind,
                                              logic [1:0] wrap);
        logic [29:0] m;
        if (kind == 2'b01) return w;
        m = (wrap == 2'b00) ? '1 : 30'((32'd1 << (wrap + 32'd1)) - 32'd1);
        return (w & ~m) | ((w + 30'd1) & m);
    endfunction

    function automatic logic [4:0] exp_tags(bit single, bit last, logic [1:0] kind,
                                            logic [1:0] wrap);
        logic [2:0] c;
        logic [1:0] b;
        if (single)            begin c = 3'b000; b = 2'b00; end
        else begin
            c = last ? 3'b111 : (kind == 2'b01 ? 3'b001 : 3'b010);
            b = (kind == 2'b01) ? 2'b00 : wrap;
        end
        return {c, b};
    endfunction

    task automatic run(input logic [31:0] a, input int len, input logic [1:0] kind,
                       input logic [1:0] wrap, input int max_stall, input bit poke);
        bit single;
        int n;
        logic [29:0] w;
        logic [4:0] tg;
        string tag;
        single = (len < 2) || (kind == 2'b00) || (kind == 2'b11);
        n = single ? 1 : len;
        w = a[31:2];
        start_i = 1'b1; start_adr_i = a; len_i = 5'(len); kind_i = kind; wrap_i = wrap;
        ack_i = 1'b0;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            bit last = (i == n - 1);
            int stalls = (max_stall == 0) ? 0 : int'($urandom_range(max_stall, 0));
            tg = exp_tags(single, last, kind, wrap);
            if (single) tag = "R8";
            else if (last) tag = "R7";
            else if (kind == 2'b01) tag = "R6";
            else if (wrap != 2'b00) tag = "R5";
            else tag = "R4";
            if (i == 0) begin
                check(cyc_o && stb_o && adr_o == {w, 2'b00}, "R2", {cyc_o, adr_o},
                      {1'b1, w, 2'b00});
                if (poke && stalls == 0) stalls = 1;
            end
            for (int s = 0; s < stalls; s++) begin
                if (poke && i == 0 && s == 0) begin
                    start_i = 1'b1; start_adr_i = ~a; len_i = 5'd1; kind_i = 2'b00;
                end
                @(posedge clk); @(negedge clk);
                start_i = 1'b0;
                check(cyc_o && adr_o == {w, 2'b00} && {cti_o, bte_o} == tg,
                      (poke && i == 0 && s == 0) ? "R9" : "R3",
                      {cyc_o, adr_o, cti_o, bte_o}, {1'b1, w, 2'b00, tg});
            end
            check(cyc_o && stb_o && adr_o == {w, 2'b00} && {cti_o, bte_o} == tg, tag,
                  {cyc_o, adr_o, cti_o, bte_o}, {1'b1, w, 2'b00, tg});
            ack_i = 1'b1;
            @(posedge clk); @(negedge clk);
            ack_i = 1'b0;
            w = next_word(w, kind, wrap);
        end
        check(!cyc_o && !stb_o, single ? "R8" : "R7", {cyc_o, stb_o}, 2'b00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        rst_n = 1'b0; start_i = 1'b0; start_adr_i = '0; len_i = '0;
        kind_i = '0; wrap_i = '0; ack_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!cyc_o && !stb_o && cti_o == 3'b000 && bte_o == 2'b00 && adr_o == '0,
              "R1", {cyc_o, stb_o, adr_o, cti_o, bte_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cyc_o && !stb_o && adr_o == '0, "R1", {cyc_o, stb_o, adr_o}, '0);

        run(32'h0000_1003, 5,  2'b10, 2'b00, 0, 1'b0); // R4 linear, unaligned start R2
        run(32'h0000_2018, 6,  2'b10, 2'b01, 1, 1'b0); // R5 wrap 4
        run(32'h0000_3034, 8,  2'b10, 2'b10, 0, 1'b0); // R5 wrap 8
        run(32'hFFFF_FFF8, 16, 2'b10, 2'b11, 0, 1'b0); // R5 wrap 16 at top
        run(32'h0000_4440, 3,  2'b01, 2'b11, 2, 1'b0); // R6 constant
        run(32'h0000_5550, 1,  2'b10, 2'b10, 0, 1'b0); // R8 length 1
        run(32'h0000_6660, 0,  2'b01, 2'b00, 0, 1'b0); // R8 length 0
        run(32'h0000_7770, 4,  2'b00, 2'b01, 0, 1'b0); // R8 classic
        run(32'h0000_8880, 7,  2'b11, 2'b10, 0, 1'b0); // R8 kind 11
        run(32'h0000_9990, 2,  2'b10, 2'b00, 0, 1'b0); // R7 two beats
        run(32'h0000_AAA0, 4,  2'b10, 2'b01, 2, 1'b1); // R9 busy start
        run(32'h0000_BBB0, 3,  2'b01, 2'b00, 1, 1'b1); // R9 busy start constant

        for (int k = 0; k < 40; k++) begin
            logic [31:0] a = $urandom;
            int len = int'($urandom_range(20, 0));
            logic [1:0] kind = 2'($urandom_range(3, 0));
            logic [1:0] wrap = 2'($urandom_range(3, 0));
            run(a, len, kind, wrap, 2, 1'b0);
            repeat (int'($urandom_range(2, 0))) @(negedge clk);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule